// File: doc/BRIEF.md
# Misaligned Access Judge

This block sits beside the address path of a load/store unit and rules on each memory access before it is issued. From the byte address, the size code, the instruction class, a compressed-encoding flag and a relaxation-enable bit, it decides one of three outcomes. The access may be performed as one indivisible operation. It may raise an address-misaligned fault. Or it may have to be broken into several bus operations, with no atomicity promised.

The relaxation works as follows. An access that is not naturally aligned still counts as a single fault-free operation if every byte it touches lies inside one naturally aligned 16-byte granule. The enable bit must be set, and the access must come from an eligible class in its full-length encoding. Misaligned accesses that do not qualify follow a baseline policy picked at build time: either fault, or request a split.

A request is presented with a one-cycle strobe. The verdict appears on registered outputs one clock later, with its own valid flag.

Top module: `mis_access_judge`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `rspValid`, `rspFault`, `rspAtomic` and `rspSplit` are all low.
- R2: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high. After a cycle with `reqValid` low it is low.
- R3: Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes, and codes 5 to 7 are treated as 16 bytes. An access whose address is a multiple of its byte count is reported atomic, with no fault and no split, whatever the class, compressed flag or enable bit.
- R4: An access stays inside its granule only if the address bits above bit 3 of its first byte equal those of its last byte. The last byte is the first byte plus the byte count minus one, wrapping modulo the address width. A misaligned access that crosses a granule never gains the relaxation.
- R5: A misaligned access that is eligible and stays inside its granule is reported atomic, with no fault and no split.
- R6: Class codes are 0 integer load, 1 integer store, 2 atomic memory operation, 3 floating-point load, 4 floating-point store, 5 compare-and-swap, and 6 and 7 other. Classes 0 to 2 are eligible. Classes 3 and 4 are eligible only when the byte count is no larger than `XLEN_BYTES`.
- R7: An access with the compressed flag set is never eligible.
- R8: Class codes 5, 6 and 7 are never eligible.
- R9: With `granEnable` low, no access is eligible.
- R10: With `FAULT_ON_BASELINE` = 1, a misaligned access that is not relaxed is reported with the fault flag high and the atomic and split flags low.
- R11: With `FAULT_ON_BASELINE` = 0, a misaligned access that is not relaxed is reported with the split flag high and the fault and atomic flags low.
- R12: Whenever `rspValid` is high, exactly one of `rspFault`, `rspAtomic` and `rspSplit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | ADDR_W | Byte address of the first byte |
| reqSize | input | 3 | Size code, log2 of the byte count |
| reqClass | input | 3 | Instruction class code |
| reqCompressed | input | 1 | Access comes from a 16-bit encoded instruction |
| granEnable | input | 1 | Enables the granule relaxation |
| rspValid | output | 1 | Verdict valid, one cycle after the request |
| rspFault | output | 1 | Raise an address-misaligned fault |
| rspAtomic | output | 1 | Perform as a single indivisible operation |
| rspSplit | output | 1 | Access must be split, no atomicity |

## Verification
The bench builds two copies of the block with an 8-bit address and `XLEN_BYTES` = 4: one with the fault baseline and one with the split baseline. With only 256 addresses, it can present every combination of address, all eight size codes, all eight class codes, the compressed flag and the enable bit, one request per cycle. That covers every granule crossing, including wrap-around at the top of the address space. The 4-byte XLEN setting makes 8-byte and 16-byte floating-point accesses ineligible, so the width rule is also exercised.

// File: rtl/mis_access_pkg.sv
package mis_access_pkg;

  typedef enum logic [2:0] {
    CLS_INT_LD = 3'd0,
    CLS_INT_ST = 3'd1,
    CLS_AMO    = 3'd2,
    CLS_FP_LD  = 3'd3,
    CLS_FP_ST  = 3'd4,
    CLS_CAS    = 3'd5,
    CLS_OTH6   = 3'd6,
    CLS_OTH7   = 3'd7
  } accClassT;

  // geometry facts the datapath reports to the control
  typedef struct packed {
    logic aligned;
    logic inGranule;
    logic fitsXlen;
  } geomT;

  // strobes the control sends to the datapath output stage
  typedef struct packed {
    logic capture;
    logic fault;
    logic atomic;
    logic split;
  } verdictT;

endpackage

// File: rtl/mis_access_datapath.sv
module mis_access_datapath
  import mis_access_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRAN_LOG2  = 4,
  parameter int XLEN_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  verdictT           verdict,
  output geomT              geom,
  output logic              rspValid,
  output logic              rspFault,
  output logic              rspAtomic,
  output logic              rspSplit
);

  localparam int          XLEN_LOG2 = $clog2(XLEN_BYTES);
  localparam logic [2:0]  MAX_CODE  = 3'(GRAN_LOG2);

  logic [2:0]        sizeLog2;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] lastAddr;

  // codes above the granule size saturate to a full granule
  assign sizeLog2 = (reqSize > MAX_CODE) ? MAX_CODE : reqSize;
  assign lowMask  = (ADDR_W'(1) << sizeLog2) - ADDR_W'(1);
  assign lastAddr = reqAddr + lowMask;

  always_comb begin
    geom.aligned   = ((reqAddr & lowMask) == '0);
    geom.inGranule = (reqAddr[ADDR_W-1:GRAN_LOG2] == lastAddr[ADDR_W-1:GRAN_LOG2]);
    geom.fitsXlen  = (int'(sizeLog2) <= XLEN_LOG2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspFault  <= 1'b0;
      rspAtomic <= 1'b0;
      rspSplit  <= 1'b0;
    end else begin
      rspValid <= verdict.capture;
      if (verdict.capture) begin
        rspFault  <= verdict.fault;
        rspAtomic <= verdict.atomic;
        rspSplit  <= verdict.split;
      end
    end
  end

endmodule

// File: rtl/mis_access_control.sv
module mis_access_control
  import mis_access_pkg::*;
#(
  parameter bit FAULT_ON_BASELINE = 1'b1
) (
  input  logic       reqValid,
  input  logic [2:0] reqClass,
  input  logic       reqCompressed,
  input  logic       granEnable,
  input  geomT       geom,
  output verdictT    verdict
);

  logic classOk;
  logic eligible;
  logic relaxed;
  logic baseFault;

  always_comb begin
    unique case (accClassT'(reqClass))
      CLS_INT_LD, CLS_INT_ST, CLS_AMO: classOk = 1'b1;
      CLS_FP_LD, CLS_FP_ST:            classOk = geom.fitsXlen;
      default:                         classOk = 1'b0;
    endcase
  end

  assign eligible = granEnable && !reqCompressed && classOk;
  assign relaxed  = eligible && geom.inGranule;

  generate
    if (FAULT_ON_BASELINE) begin : g_faultBase
      assign baseFault = 1'b1;
    end else begin : g_splitBase
      assign baseFault = 1'b0;
    end
  endgenerate

  always_comb begin
    verdict.capture = reqValid;
    verdict.atomic  = geom.aligned || relaxed;
    verdict.fault   = !verdict.atomic && baseFault;
    verdict.split   = !verdict.atomic && !baseFault;
  end

endmodule

// File: rtl/mis_access_judge.sv
module mis_access_judge
  import mis_access_pkg::*;
#(
  parameter int ADDR_W            = 32,
  parameter int GRAN_LOG2         = 4,
  parameter int XLEN_BYTES        = 8,
  parameter bit FAULT_ON_BASELINE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [2:0]        reqClass,
  input  logic              reqCompressed,
  input  logic              granEnable,
  output logic              rspValid,
  output logic              rspFault,
  output logic              rspAtomic,
  output logic              rspSplit
);

  geomT    geom;
  verdictT verdict;

  mis_access_control #(
    .FAULT_ON_BASELINE(FAULT_ON_BASELINE)
  ) u_control (
    .reqValid     (reqValid),
    .reqClass     (reqClass),
    .reqCompressed(reqCompressed),
    .granEnable   (granEnable),
    .geom         (geom),
    .verdict      (verdict)
  );

  mis_access_datapath #(
    .ADDR_W    (ADDR_W),
    .GRAN_LOG2 (GRAN_LOG2),
    .XLEN_BYTES(XLEN_BYTES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .verdict  (verdict),
    .geom     (geom),
    .rspValid (rspValid),
    .rspFault (rspFault),
    .rspAtomic(rspAtomic),
    .rspSplit (rspSplit)
  );

endmodule

// File: rtl/mis_access_judge_chk.sv
module mis_access_judge_chk #(
  parameter int ADDR_W            = 32,
  parameter bit FAULT_ON_BASELINE = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [2:0]        reqSize,
  input logic [2:0]        reqClass,
  input logic              reqCompressed,
  input logic              granEnable,
  input logic              rspValid,
  input logic              rspFault,
  input logic              rspAtomic,
  input logic              rspSplit
);

  logic misaligned;

  always_comb begin
    case (reqSize)
      3'd0:    misaligned = 1'b0;
      3'd1:    misaligned = reqAddr[0];
      3'd2:    misaligned = |reqAddr[1:0];
      3'd3:    misaligned = |reqAddr[2:0];
      default: misaligned = |reqAddr[3:0];
    endcase
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R12
  one_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones({rspFault, rspAtomic, rspSplit}) == 1));

  // R3
  aligned_atomic_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !misaligned) |=> rspAtomic);

  // R7
  compressed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && misaligned && reqCompressed) |=> !rspAtomic);

  // R8
  cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && misaligned && (reqClass >= 3'd5)) |=> !rspAtomic);

  // R9
  disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && misaligned && !granEnable) |=> !rspAtomic);

  // R10 R11
  policy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (FAULT_ON_BASELINE ? !rspSplit : !rspFault));

endmodule

bind mis_access_judge mis_access_judge_chk #(
  .ADDR_W           (ADDR_W),
  .FAULT_ON_BASELINE(FAULT_ON_BASELINE)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqAddr      (reqAddr),
  .reqSize      (reqSize),
  .reqClass     (reqClass),
  .reqCompressed(reqCompressed),
  .granEnable   (granEnable),
  .rspValid     (rspValid),
  .rspFault     (rspFault),
  .rspAtomic    (rspAtomic),
  .rspSplit     (rspSplit)
);

// File: tb/mis_access_judge_tb.sv
`timescale 1ns/1ps
module mis_access_judge_tb;

  localparam int AW = 8;
  localparam int XB = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [2:0]    reqSize = '0;
  logic [2:0]    reqClass = '0;
  logic          reqCompressed = 1'b0;
  logic          granEnable = 1'b0;
  logic          fV, fF, fA, fS;
  logic          sV, sF, sA, sS;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mis_access_judge #(.ADDR_W(AW), .XLEN_BYTES(XB), .FAULT_ON_BASELINE(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqClass(reqClass), .reqCompressed(reqCompressed), .granEnable(granEnable),
    .rspValid(fV), .rspFault(fF), .rspAtomic(fA), .rspSplit(fS));

  mis_access_judge #(.ADDR_W(AW), .XLEN_BYTES(XB), .FAULT_ON_BASELINE(1'b0)) u_dutSplit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqClass(reqClass), .reqCompressed(reqCompressed), .granEnable(granEnable),
    .rspValid(sV), .rspFault(sF), .rspAtomic(sA), .rspSplit(sS));

  task automatic checkOne(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d size=%0d cls=%0d cmp=%0b en=%0b {v,f,a,s} act=%b exp=%b",
               tag, reqAddr, reqSize, reqClass, reqCompressed, granEnable, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    checkOne("R1 fault-mode", {fV, fF, fA, fS}, 4'b0000);
    checkOne("R1 split-mode", {sV, sF, sA, sS}, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkOne("R1 first-edge", {fV, fF, fA, fS}, 4'b0000);
    checkOne("R2 idle", {sV, 3'b000}, 4'b0000);

    for (int a = 0; a < 256; a++) begin
      for (int sz = 0; sz < 8; sz++) begin
        for (int cl = 0; cl < 8; cl++) begin
          for (int m = 0; m < 4; m++) begin
            int    sl, nb, last;
            bit    algn, inG, clsOk, elig, atom;
            string tag;
            @(negedge clk);
            reqValid      = 1'b1;
            reqAddr       = AW'(a);
            reqSize       = 3'(sz);
            reqClass      = 3'(cl);
            reqCompressed = m[0];
            granEnable    = m[1];
            sl    = (sz > 4) ? 4 : sz;
            nb    = 1 << sl;
            algn  = (a % nb) == 0;
            last  = (a + nb - 1) % 256;
            inG   = (a / 16) == (last / 16);
            clsOk = (cl <= 2) || (((cl == 3) || (cl == 4)) && (nb <= XB));
            elig  = m[1] && !m[0] && clsOk;
            atom  = algn || (elig && inG);
            if (algn)             tag = "R3";
            else if (elig && inG) tag = "R5";
            else if (!m[1])       tag = "R9";
            else if (m[0])        tag = "R7";
            else if (cl >= 5)     tag = "R8";
            else if (!clsOk)      tag = "R6";
            else                  tag = "R4";
            @(posedge clk);
            #1;
            // R2 R12 via expected one-hot encoding
            checkOne({tag, " R10 R2"}, {fV, fF, fA, fS}, {1'b1, !atom, atom, 1'b0});
            checkOne({tag, " R11 R12"}, {sV, sF, sA, sS}, {1'b1, 1'b0, atom, !atom});
          end
        end
      end
    end

    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    checkOne("R2 drop", {fV, sV, 2'b00}, 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule